// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Master and Slave Sides

This block moves eight-bit frames over a four-wire serial link. As master it generates the serial clock, drives the outgoing data line and frames each transfer with an active-low select. As slave it follows an external clock and select and returns a byte of its own on the return line. Software sees it through four byte-wide registers on a simple bus: configuration, data (write to transmit, read to receive), status, and a manual select level.

The configuration register picks the master clock rate, whether the select is framed by hardware or by software, what happens when a byte arrives before the previous one was read, which condition raises the interrupt line, and whether the block is slave and whether the slave honours its select input. The transmit and receive sides each hold one byte. Writing a byte while the previous one is still shifting produces a gap-free continuous burst.

Top module: `spi_port`

## Requirements
- R1: After reset the configuration register (address 0) reads 0x10, the status register (address 2) reads 0x02, ssOut is 1, sclkOut is 0 and irq is 0.
- R2: In master mode the rate field (configuration bits 1:0) gives a full SCLK period of 8, 16, 32 or 64 core cycles for codes 0, 1, 2 and 3; SCLK idles low.
- R3: Master frames are 8 bits, MSB first: mosiOut changes only after a falling SCLK edge, misoIn is sampled on the rising edge, and the byte read from address 1 equals the byte shifted in.
- R4: With the auto-select bit (configuration bit 4) set, ssOut is low while a byte shifts; a lone byte produces one low pulse, and ssOut is high whenever the master is idle.
- R5: With auto-select, a byte written before the current one finishes continues the burst with ssOut held low; if no byte is waiting when a frame ends, ssOut rises.
- R6: With auto-select cleared, ssOut follows bit 0 of the select-level register (address 3, reset 1), also during transfers.
- R7: When a byte arrives while the receive register is still full, configuration bit 2 at 0 keeps the old byte and at 1 replaces it with the new one.
- R8: Status bit 2 is a sticky overflow flag set by such an arrival under either policy and cleared by any write to address 2.
- R9: Reading address 1 clears the receive-full flag (status bit 0); writing address 1 clears the transmit-empty flag (status bit 1) in the next cycle; status bit 3 shows a master transfer in progress.
- R10: With configuration bit 5 at 0, irq equals the receive-full flag; at 1, irq equals the transmit-empty flag.
- R11: With configuration bit 6 set the block is a slave: SCLK stays low and ssOut high; it shifts mosiIn in on rising sclkIn edges and presents its transmit byte MSB first on misoOut; with configuration bit 3 set it shifts only while ssIn is low, otherwise it ignores ssIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears receive-full at address 1) |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| sclkOut | output | 1 | Master serial clock |
| mosiOut | output | 1 | Master data out |
| misoIn | input | 1 | Master data in |
| ssOut | output | 1 | Master select, active low |
| sclkIn | input | 1 | Slave serial clock |
| mosiIn | input | 1 | Slave data in |
| ssIn | input | 1 | Slave select, active low |
| misoOut | output | 1 | Slave data out |
| irq | output | 1 | Interrupt level |

## Verification
Register writes take effect at the clock edge of the strobe, so the select level, transmit-empty and irq are compared at the first falling clock edge after the write. A master frame starts one cycle after the transmit write and lasts 16 half-periods, so the bench polls the busy and transmit-empty status bits until the frame has ended before reading received data, while a monitor rebuilds each MOSI byte from the SCLK rising edges and measures the rise-to-rise spacing. Slave inputs pass through a two-stage synchronizer plus one edge stage, so the bench holds each serial level for four core cycles and waits six more after the last edge before reading.

// File: rtl/spi_pkg.sv
package spi_pkg;

  // Field order gives register bit positions 6..0
  typedef struct packed {
    logic       slaveMode;
    logic       intOnTxEmpty;
    logic       autoSs;
    logic       ssEnable;
    logic       overwrite;
    logic [1:0] rate;
  } spiCfg_t;

  localparam int CFG_W = $bits(spiCfg_t);

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_SSLV = 2'd3;

  localparam spiCfg_t CFG_RESET = '{slaveMode: 1'b0, intOnTxEmpty: 1'b0,
                                    autoSs: 1'b1, ssEnable: 1'b0,
                                    overwrite: 1'b0, rate: 2'd0};

  // Strobes from control to datapath
  typedef struct packed {
    logic wrTx;
    logic rdRx;
    logic clrOvf;
    logic mLoad;
    logic mCapture;
    logic mShift;
    logic mDone;
    logic sLoad;
    logic sShift;
    logic sDone;
    logic sBit;
  } spiStb_t;

endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF_MIN = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  input  logic          txFull,
  input  logic          sclkIn,
  input  logic          ssIn,
  input  logic          mosiIn,
  output spiCfg_t       cfg,
  output spiStb_t       stb,
  output logic          manLevel,
  output logic          busy,
  output logic          sclkOut,
  output logic          ssOut
);

  localparam int HALF_W = $clog2(HALF_MIN) + 4;
  localparam int BIT_W  = $clog2(DW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  // ---------------- register decode ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= CFG_RESET;
      manLevel <= 1'b1;
    end else if (regWr) begin
      if (regAddr == ADDR_CFG)  cfg      <= spiCfg_t'(regWdata[CFG_W-1:0]);
      if (regAddr == ADDR_SSLV) manLevel <= regWdata[0];
    end
  end

  // ---------------- master sequencer ----------------
  logic              run;
  logic              sclkQ;
  logic [HALF_W-1:0] divCnt;
  logic [HALF_W-1:0] halfLen;
  logic [BIT_W-1:0]  bitCnt;
  logic              divTerm;
  logic              startOk;
  logic              fallEdge;

  assign halfLen  = HALF_W'(HALF_MIN) << cfg.rate;
  assign divTerm  = run && (divCnt == halfLen - HALF_W'(1));
  assign startOk  = !run && !cfg.slaveMode && txFull;
  assign fallEdge = divTerm && sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run    <= 1'b0;
      sclkQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (!run) begin
      run    <= startOk;
      sclkQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (divTerm) begin
      divCnt <= '0;
      sclkQ  <= !sclkQ;
      if (sclkQ) begin
        if (bitCnt == LAST_BIT) begin
          bitCnt <= '0;
          if (!txFull) run <= 1'b0;
        end else begin
          bitCnt <= bitCnt + BIT_W'(1);
        end
      end
    end else begin
      divCnt <= divCnt + HALF_W'(1);
    end
  end

  // ---------------- slave front end ----------------
  logic [2:0]       sclkSy;
  logic [1:0]       ssSy;
  logic [1:0]       mosiSy;
  logic [BIT_W-1:0] sCnt;
  logic             sRise;
  logic             sSel;
  logic             sShiftW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSy <= '0;
      ssSy   <= '1;
      mosiSy <= '0;
    end else begin
      sclkSy <= {sclkSy[1:0], sclkIn};
      ssSy   <= {ssSy[0], ssIn};
      mosiSy <= {mosiSy[0], mosiIn};
    end
  end

  assign sRise   = sclkSy[1] && !sclkSy[2];
  assign sSel    = cfg.slaveMode && (!cfg.ssEnable || !ssSy[1]);
  assign sShiftW = sSel && sRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sCnt <= '0;
    else if (!sSel)             sCnt <= '0;
    else if (sShiftW)           sCnt <= (sCnt == LAST_BIT) ? '0 : sCnt + BIT_W'(1);
  end

  // ---------------- strobes ----------------
  always_comb begin
    stb          = '0;
    stb.wrTx     = regWr && (regAddr == ADDR_DATA);
    stb.rdRx     = regRd && (regAddr == ADDR_DATA);
    stb.clrOvf   = regWr && (regAddr == ADDR_STAT);
    stb.mCapture = divTerm && !sclkQ;
    stb.mShift   = fallEdge && (bitCnt != LAST_BIT);
    stb.mDone    = fallEdge && (bitCnt == LAST_BIT);
    stb.mLoad    = startOk || (stb.mDone && txFull);
    stb.sShift   = sShiftW;
    stb.sDone    = sShiftW && (sCnt == LAST_BIT);
    stb.sLoad    = cfg.slaveMode && !sShiftW && (sCnt == '0) && txFull;
    stb.sBit     = mosiSy[1];
  end

  assign busy    = run;
  assign sclkOut = sclkQ;
  assign ssOut   = cfg.slaveMode ? 1'b1 : (cfg.autoSs ? !run : manLevel);

endmodule

// File: rtl/spi_dp.sv
module spi_dp
  import spi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  spiStb_t       stb,
  input  spiCfg_t       cfg,
  input  logic          manLevel,
  input  logic          busy,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  input  logic          misoIn,
  output logic [DW-1:0] regRdata,
  output logic          txFull,
  output logic          rxFull,
  output logic          ovf,
  output logic          mosiOut,
  output logic          misoOut,
  output logic          irq
);

  logic [DW-1:0] txBuf;
  logic [DW-1:0] rxBuf;
  logic [DW-1:0] mSh;
  logic [DW-1:0] sSh;
  logic          misoBit;
  logic          newValid;
  logic [DW-1:0] newByte;

  assign newValid = stb.mDone || stb.sDone;
  assign newByte  = stb.mDone ? {mSh[DW-2:0], misoBit} : {sSh[DW-2:0], stb.sBit};

  // transmit holding byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      txFull <= 1'b0;
    end else begin
      if (stb.wrTx) txBuf <= regWdata;
      if (stb.wrTx)                       txFull <= 1'b1;
      else if (stb.mLoad || stb.sLoad)    txFull <= 1'b0;
    end
  end

  // master and slave shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSh     <= '0;
      sSh     <= '0;
      misoBit <= 1'b0;
    end else begin
      if (stb.mCapture) misoBit <= misoIn;
      if (stb.mLoad)       mSh <= txBuf;
      else if (stb.mShift) mSh <= {mSh[DW-2:0], misoBit};
      if (stb.sShift)      sSh <= {sSh[DW-2:0], stb.sBit};
      else if (stb.sLoad)  sSh <= txBuf;
    end
  end

  // receive holding byte and overflow policy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (stb.clrOvf) ovf <= 1'b0;
      if (newValid) begin
        if (!rxFull || cfg.overwrite) rxBuf <= newByte;
        if (rxFull) ovf <= 1'b1;
        rxFull <= 1'b1;
      end else if (stb.rdRx) begin
        rxFull <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdata = DW'(cfg);
      ADDR_DATA: regRdata = rxBuf;
      ADDR_STAT: regRdata = DW'({busy, ovf, !txFull, rxFull});
      default:   regRdata = DW'(manLevel);
    endcase
  end

  assign mosiOut = mSh[DW-1];
  assign misoOut = sSh[DW-1];
  assign irq     = cfg.intOnTxEmpty ? !txFull : rxFull;

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF_MIN = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [1:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          sclkOut,
  output logic          mosiOut,
  input  logic          misoIn,
  output logic          ssOut,
  input  logic          sclkIn,
  input  logic          mosiIn,
  input  logic          ssIn,
  output logic          misoOut,
  output logic          irq
);

  spiCfg_t cfg;
  spiStb_t stb;
  logic    manLevel;
  logic    busy;
  logic    txFull;
  logic    rxFull;
  logic    ovf;
  logic    cfgAuto;
  logic    cfgSlave;

  assign cfgAuto  = cfg.autoSs;
  assign cfgSlave = cfg.slaveMode;

  spi_ctrl #(.DW(DW), .HALF_MIN(HALF_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .txFull(txFull), .sclkIn(sclkIn), .ssIn(ssIn),
    .mosiIn(mosiIn), .cfg(cfg), .stb(stb), .manLevel(manLevel), .busy(busy),
    .sclkOut(sclkOut), .ssOut(ssOut)
  );

  spi_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .manLevel(manLevel),
    .busy(busy), .regAddr(regAddr), .regWdata(regWdata), .misoIn(misoIn),
    .regRdata(regRdata), .txFull(txFull), .rxFull(rxFull), .ovf(ovf),
    .mosiOut(mosiOut), .misoOut(misoOut), .irq(irq)
  );

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic       regRd,
  input logic [1:0] regAddr,
  input logic       sclkOut,
  input logic       ssOut,
  input logic       busy,
  input logic       cfgAuto,
  input logic       cfgSlave,
  input logic       txFull,
  input logic       rxFull,
  input logic       ovf
);

  // R2
  sclk_min_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |=> sclkOut);

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> busy);

  // R4
  auto_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAuto && !cfgSlave && !busy) |-> ssOut);

  // R11
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSlave && !busy) |-> (ssOut && !sclkOut));

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(rxFull));

  // R9
  tx_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd1) |=> txFull);

  // R9
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(regRd && regAddr == 2'd1));

endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .sclkOut(sclkOut), .ssOut(ssOut), .busy(busy), .cfgAuto(cfgAuto),
  .cfgSlave(cfgSlave), .txFull(txFull), .rxFull(rxFull), .ovf(ovf)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rstN = 0, regWr = 0, regRd = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0;
  wire  [7:0] regRdata;
  wire        sclkOut, mosiOut, ssOut, misoOut, irq;
  logic       misoIn = 0, sclkIn = 0, mosiIn = 0, ssIn = 1;

  spi_port dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclkOut(sclkOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .ssOut(ssOut), .sclkIn(sclkIn),
    .mosiIn(mosiIn), .ssIn(ssIn), .misoOut(misoOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] expQ[$];
  logic [7:0] slvByte = 0;
  logic [7:0] monByte = 0;
  int cyc = 0, lastRise = 0, lastPer = 0, monBit = 0, ssRises = 0;
  logic sclkPrev = 0, ssPrev = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: rebuild MOSI bytes, play the remote slave on misoIn
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (sclkOut && !sclkPrev) begin
        chk(ssOut == 1'b0, "R4 R6 select low while shifting", ssOut, 0);
        monByte  = {monByte[6:0], mosiOut};
        lastPer  = cyc - lastRise;
        lastRise = cyc;
        monBit++;
        if (monBit == 8) begin
          logic [7:0] e;
          monBit = 0;
          if (expQ.size() == 0) chk(1'b0, "R3 unexpected MOSI byte", monByte, 0);
          else begin
            e = expQ.pop_front();
            chk(monByte == e, "R3 MOSI byte", monByte, e);
          end
        end
      end
      if (ssOut && !ssPrev) ssRises++;
    end
    sclkPrev = sclkOut;
    ssPrev   = ssOut;
    misoIn   = slvByte[7 - monBit];
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1; #1 d = regRdata;
    @(negedge clk); regRd = 0;
  endtask

  task automatic sendM(input logic [7:0] b);
    expQ.push_back(b);
    wrReg(2'd1, b);
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rdReg(2'd2, s);
      if (!s[3] && s[1]) break;
    end
  endtask

  task automatic slvXfer(input logic [7:0] b, input bit selLow, output logic [7:0] got);
    ssIn = !selLow;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosiIn = b[i];
      repeat (4) @(negedge clk);
      got[i] = misoOut;
      sclkIn = 1;
      repeat (4) @(negedge clk);
      sclkIn = 0;
    end
    repeat (4) @(negedge clk);
    ssIn = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, g;
    int r0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rdReg(2'd0, r); chk(r == 8'h10, "R1 config reset", r, 8'h10);
    rdReg(2'd2, r); chk(r == 8'h02, "R1 status reset", r, 8'h02);
    chk(ssOut == 1 && sclkOut == 0 && irq == 0, "R1 pins reset",
        {ssOut, sclkOut, irq}, 3'b100);

    // Single auto-framed byte at the fastest rate
    slvByte = 8'h3C;
    r0 = ssRises;
    sendM(8'hA5);
    waitIdle();
    chk(ssRises == r0 + 1, "R4 one select pulse", ssRises - r0, 1);
    chk(lastPer == 8, "R2 period code 0", lastPer, 8);
    rdReg(2'd2, r); chk(r[0] == 1, "R9 receive full set", r[0], 1);
    chk(irq == 1, "R10 irq on receive full", irq, 1);
    rdReg(2'd1, r); chk(r == 8'h3C, "R3 received byte", r, 8'h3C);
    rdReg(2'd2, r); chk(r[0] == 0, "R9 read clears receive full", r[0], 0);
    chk(irq == 0, "R10 irq drops after read", irq, 0);

    // Slower rates
    for (int code = 1; code < 4; code++) begin
      wrReg(2'd0, 8'h10 | 8'(code));
      slvByte = 8'h5A + 8'(code);
      sendM(8'hC0 + 8'(code));
      waitIdle();
      chk(lastPer == (8 << code), "R2 period", lastPer, 8 << code);
      rdReg(2'd1, r); chk(r == slvByte, "R3 received byte at rate", r, slvByte);
    end

    // Continuous burst of three bytes
    wrReg(2'd0, 8'h14);
    slvByte = 8'h96;
    r0 = ssRises;
    sendM(8'h81);
    sendM(8'h42);
    for (int i = 0; i < 500; i++) begin
      rdReg(2'd2, r);
      if (r[1]) break;
    end
    sendM(8'h24);
    waitIdle();
    chk(ssRises == r0 + 1, "R5 burst keeps select low", ssRises - r0, 1);
    rdReg(2'd1, r);
    wrReg(2'd2, 8'h00);

    // Two separate bytes give two pulses
    r0 = ssRises;
    sendM(8'h11); waitIdle();
    sendM(8'h22); waitIdle();
    chk(ssRises == r0 + 2, "R5 idle gap releases select", ssRises - r0, 2);
    rdReg(2'd1, r);
    wrReg(2'd2, 8'h00);

    // Overflow: discard policy
    wrReg(2'd0, 8'h10);
    slvByte = 8'h11; sendM(8'h01); waitIdle();
    slvByte = 8'h22; sendM(8'h02); waitIdle();
    rdReg(2'd2, r); chk(r[2] == 1, "R8 overflow flag set", r[2], 1);
    rdReg(2'd1, r); chk(r == 8'h11, "R7 discard keeps old byte", r, 8'h11);
    wrReg(2'd2, 8'h00);
    rdReg(2'd2, r); chk(r[2] == 0, "R8 overflow flag cleared", r[2], 0);

    // Overflow: overwrite policy
    wrReg(2'd0, 8'h14);
    slvByte = 8'h33; sendM(8'h03); waitIdle();
    slvByte = 8'h44; sendM(8'h04); waitIdle();
    rdReg(2'd1, r); chk(r == 8'h44, "R7 overwrite keeps new byte", r, 8'h44);
    rdReg(2'd2, r); chk(r[2] == 1, "R8 flag under overwrite", r[2], 1);
    wrReg(2'd2, 8'h00);

    // Manual select
    wrReg(2'd0, 8'h00);
    wrReg(2'd3, 8'h00);
    chk(ssOut == 0, "R6 manual select low", ssOut, 0);
    r0 = ssRises;
    slvByte = 8'h77;
    sendM(8'h6E);
    waitIdle();
    chk(ssRises == r0 && ssOut == 0, "R6 transfer leaves manual level", ssOut, 0);
    rdReg(2'd1, r);
    wrReg(2'd3, 8'h01);
    chk(ssOut == 1, "R6 manual select high", ssOut, 1);

    // Interrupt on transmit empty
    wrReg(2'd0, 8'h30);
    chk(irq == 1, "R10 irq on transmit empty", irq, 1);
    sendM(8'h5D);
    chk(irq == 0, "R9 R10 write clears transmit empty", irq, 0);
    waitIdle();
    chk(irq == 1, "R10 irq after byte consumed", irq, 1);
    rdReg(2'd1, r);

    // Slave mode with select enable
    wrReg(2'd0, 8'h48);
    wrReg(2'd1, 8'hC3);
    chk(sclkOut == 0 && ssOut == 1, "R11 master pins quiet", {sclkOut, ssOut}, 2'b01);
    slvXfer(8'h99, 1'b0, g);
    rdReg(2'd2, r); chk(r[0] == 0, "R11 ignored while select high", r[0], 0);
    slvXfer(8'h66, 1'b1, g);
    chk(g == 8'hC3, "R11 slave MISO byte", g, 8'hC3);
    rdReg(2'd1, r); chk(r == 8'h66, "R11 slave received byte", r, 8'h66);

    // Slave mode without select enable
    wrReg(2'd0, 8'h40);
    slvXfer(8'h0F, 1'b0, g);
    rdReg(2'd1, r); chk(r == 8'h0F, "R11 select ignored when disabled", r, 8'h0F);

    chk(expQ.size() == 0, "R3 all bytes seen", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule